// File: doc/BRIEF.md
# Data-Edge Lead/Lag Phase Detector

This block sits at the front of a digital bit-timing recovery loop. It watches a received serial data line and compares each rising transition with the level of the locally generated bit-rate clock. It runs on the fast oversampling clock. If the local bit clock is already high when a data rise is seen, the local clock is ahead, and the block emits a one-cycle deduct pulse. If the clock is still low, the local clock is behind, and the block emits a one-cycle add pulse. It also brings out the raw one-cycle edge strobe.

The serial data comes from another timing domain, so it passes through a synchronizer chain of configurable depth before edges are detected. The downstream loop controller drives an add-enable input. When the controller pulls that input low, the add path is blocked. The controller does this after a deduct to break the false lock that occurs when the recovered clock sits in antiphase with the data. The deduct path is never blocked. Filtering of the pulses and the actual clock adjustment belong to other blocks.

Top module: `lead_lag_pd`

## Requirements
- R1: While reset (rstN low) is asserted, and on the first cycle after it is released, edgePulse, deductPulse and addPulse are all low.
- R2: A rising transition on serialIn, held stable, raises edgePulse for exactly one cycle. The pulse is seen after the (SYNC_STAGES+1)th rising clock edge that follows the change. With the default SYNC_STAGES=2, that is after the third edge.
- R3: A falling transition on serialIn, or a steady level of either value, produces no pulse on any output.
- R4: If bitClk is high at the clock edge that registers the edge strobe, deductPulse is high in the same cycle as edgePulse. This is the clock-ahead decision. At that edge addPulse is low.
- R5: If bitClk is low at that deciding edge and addEnable is high, addPulse is high in the same cycle as edgePulse. This is the clock-behind decision. At that edge deductPulse is low.
- R6: If bitClk is low and addEnable is low at the deciding edge, neither deductPulse nor addPulse fires. edgePulse still fires.
- R7: deductPulse and addPulse are never high in the same cycle.
- R8: deductPulse and addPulse are only ever high in a cycle in which edgePulse is high.
- R9: The level of addEnable has no effect on deductPulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| serialIn | input | 1 | Received serial data, from another timing domain |
| bitClk | input | 1 | Recovered bit-rate clock level, synchronous to clk |
| addEnable | input | 1 | High allows add pulses; low blocks them |
| edgePulse | output | 1 | One-cycle strobe for each detected data rise |
| deductPulse | output | 1 | One-cycle strobe: local clock ahead |
| addPulse | output | 1 | One-cycle strobe: local clock behind |

## Verification
A wrong synchronizer depth or a wrong edge history shows as a strobe one cycle early or late, or as a strobe that repeats on a held level. Either is visible on edgePulse within a few cycles of one data rise. A decision taken from a stale or inverted bitClk, or a leak through the add gate, appears at once as the wrong strobe beside edgePulse. For that reason every vector samples the cycle of the strobe and the cycles on each side of it. A stuck direction register would also break the rule that the two decision strobes never fire together, and that each one fires only with edgePulse.

// File: rtl/lead_lag_pd_pkg.sv
package lead_lag_pd_pkg;
  typedef struct packed {
    logic markEdge;
    logic markDeduct;
    logic markAdd;
  } pdStrobes_t;
endpackage

// File: rtl/lead_lag_pd_dp.sv
module lead_lag_pd_dp
  import lead_lag_pd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serialIn,
  input  pdStrobes_t strobes,
  output logic       edgeNow,
  output logic       edgePulse,
  output logic       deductPulse,
  output logic       addPulse
);
  localparam int CHAIN_LEN = SYNC_STAGES + 1;

  logic [CHAIN_LEN-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < CHAIN_LEN; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) chain[gi] <= 1'b0;
          else       chain[gi] <= serialIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rstN) chain[gi] <= 1'b0;
          else       chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  // newest synchronized sample high, previous one low
  assign edgeNow = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgePulse   <= 1'b0;
      deductPulse <= 1'b0;
      addPulse    <= 1'b0;
    end else begin
      edgePulse   <= strobes.markEdge;
      deductPulse <= strobes.markDeduct;
      addPulse    <= strobes.markAdd;
    end
  end
endmodule

// File: rtl/lead_lag_pd_ctl.sv
module lead_lag_pd_ctl
  import lead_lag_pd_pkg::*;
(
  input  logic       edgeNow,
  input  logic       bitClk,
  input  logic       addEnable,
  output pdStrobes_t strobes
);
  always_comb begin
    strobes.markEdge   = edgeNow;
    strobes.markDeduct = edgeNow & bitClk;
    strobes.markAdd    = edgeNow & ~bitClk & addEnable;
  end
endmodule

// File: rtl/lead_lag_pd.sv
module lead_lag_pd
  import lead_lag_pd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic serialIn,
  input  logic bitClk,
  input  logic addEnable,
  output logic edgePulse,
  output logic deductPulse,
  output logic addPulse
);
  logic       edgeNow;
  pdStrobes_t strobes;

  lead_lag_pd_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .strobes(strobes),
    .edgeNow(edgeNow), .edgePulse(edgePulse),
    .deductPulse(deductPulse), .addPulse(addPulse)
  );

  lead_lag_pd_ctl u_ctl (
    .edgeNow(edgeNow), .bitClk(bitClk), .addEnable(addEnable),
    .strobes(strobes)
  );
endmodule

// File: rtl/lead_lag_pd_chk.sv
module lead_lag_pd_chk (
  input logic clk,
  input logic rstN,
  input logic bitClk,
  input logic addEnable,
  input logic edgePulse,
  input logic deductPulse,
  input logic addPulse
);
  AST_NO_DOUBLE: assert property (@(posedge clk) disable iff (!rstN)
    !(deductPulse && addPulse)); // R7
  AST_DEDUCT_WITH_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    deductPulse |-> edgePulse); // R8
  AST_ADD_WITH_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    addPulse |-> edgePulse); // R8
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    edgePulse |=> !edgePulse); // R2
  AST_DEDUCT_CLK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    deductPulse |-> $past(bitClk)); // R4
  AST_ADD_CLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    addPulse |-> !$past(bitClk)); // R5
  AST_ADD_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    addPulse |-> $past(addEnable)); // R6
endmodule

bind lead_lag_pd lead_lag_pd_chk u_chk (
  .clk(clk), .rstN(rstN), .bitClk(bitClk), .addEnable(addEnable),
  .edgePulse(edgePulse), .deductPulse(deductPulse), .addPulse(addPulse)
);

// File: tb/sim_lead_lag_pd.sv
module sim_lead_lag_pd;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serialIn = 1'b0;
  logic bitClk = 1'b0;
  logic addEnable = 1'b1;
  logic edgePulse, deductPulse, addPulse;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lead_lag_pd #(.SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .bitClk(bitClk),
    .addEnable(addEnable), .edgePulse(edgePulse),
    .deductPulse(deductPulse), .addPulse(addPulse)
  );

  // {bitClk, addEnable, expected deduct, expected add}
  localparam logic [3:0] VECS [6] = '{
    4'b1110, 4'b0101, 4'b0000, 4'b1010, 4'b0101, 4'b1110
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s edge/deduct/add actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [2:0] outs();
    return {edgePulse, deductPulse, addPulse};
  endfunction

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, outs(), 3'b000);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", outs(), 3'b000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", outs(), 3'b000);
    quiet(3, "R3 steady low");

    for (int v = 0; v < 6; v++) begin
      @(negedge clk);
      bitClk = VECS[v][3];
      addEnable = VECS[v][2];
      serialIn = 1'b1;
      @(negedge clk); check("R2 no early strobe", outs(), 3'b000);
      @(negedge clk); check("R2 no early strobe", outs(), 3'b000);
      @(negedge clk);
      check("R4 R5 R6 R9 decision", outs(), {1'b1, VECS[v][1], VECS[v][0]});
      @(negedge clk); check("R2 single cycle", outs(), 3'b000);
      quiet(3, "R3 steady high");
      serialIn = 1'b0;
      quiet(5, "R3 falling edge");
    end

    // bitClk changes between input change and deciding edge: late value rules
    @(negedge clk);
    bitClk = 1'b0; addEnable = 1'b1; serialIn = 1'b1;
    @(negedge clk); @(negedge clk);
    bitClk = 1'b1;
    @(negedge clk);
    check("R4 late clock high", outs(), 3'b110);
    bitClk = 1'b0;
    quiet(2, "R2 single cycle");
    serialIn = 1'b0;
    quiet(4, "R3 falling edge");

    // short glitch high for one cycle still yields one strobe
    @(negedge clk);
    bitClk = 1'b0; addEnable = 1'b1; serialIn = 1'b1;
    @(negedge clk); serialIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R5 short pulse add", outs(), 3'b101);
    quiet(4, "R3 after short pulse");

    // reset in the middle of a pending edge clears it
    @(negedge clk);
    serialIn = 1'b1; bitClk = 1'b1;
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); check("R1 reset mid-edge", outs(), 3'b000);
    serialIn = 1'b0;
    @(negedge clk); rstN = 1'b1;
    quiet(4, "R1 quiet after reset");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule